// File: doc/BRIEF.md
# Reprogrammable Four-Input Lookup Logic Element

This block is a single programmable logic element. A sixteen-entry truth table is indexed by four logic inputs. The element then sends the selected bit either straight to its output or through a flip-flop. The storage cells behave like nonvolatile memory: they keep their contents through reset, and they change only through dedicated set and clear operations.

A small sequencer owns three mutually exclusive mode enables: read, erase and write. When a configuration load strobe arrives, the sequencer clears every cell in turn, one cell per clock. It then sets, again one per clock, only the cells whose new truth-table entry is 1. After that it returns to read mode. The cells are laid out physically in Gray-code order: the cell at position p holds entry p^(p>>1). The address decoder uses true and complemented forms of each input to find the correct cell.

Top module: `ble4_lut_element`

## Requirements
- R1: In combinational mode (cfg_registered captured as 0) and when not busy, lut_out equals bit lut_in of the most recently loaded cfg_table (bit 0 is the entry for input 0000, bit 15 for 1111).
- R2: Exactly one of the read, erase and write enables is active in every cycle, and read is active whenever busy is low.
- R3: A cfg_load pulse seen while idle raises busy at the next clock edge. Busy then stays high for exactly 16 plus the number of 1 bits in cfg_table cycles: one erase cycle per cell and one write cycle per set entry.
- R4: Every cell is cleared before any cell is written. Entries that were 1 in the old table and 0 in the new one therefore read 0 after reprogramming.
- R5: In registered mode (cfg_registered captured as 1), lut_out equals the table entry addressed by lut_in at the previous rising clock edge.
- R6: While busy is high, lut_out holds the value it had when the load was accepted, whatever lut_in does, and the flip-flop captures nothing.
- R7: A cfg_load pulse while busy is ignored. The table and the mode from the accepted load take effect, and the busy length is unchanged.
- R8: Reset clears the flip-flop, so lut_out reads 0 in registered mode during reset. Reset does not clear the truth table or the output mode.
- R9: The cell contents do not change while read mode is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lut_in | input | 4 | Logic inputs used as the table index |
| cfg_load | input | 1 | Strobe that starts reprogramming |
| cfg_table | input | 16 | New truth table, sampled with cfg_load |
| cfg_registered | input | 1 | Output mode sampled with cfg_load: 1 registered, 0 combinational |
| lut_out | output | 1 | Logic output |
| busy | output | 1 | High while erase or write is in progress |

## Verification
The bench sweeps all sixteen indices over several tables, including all-zero, all-one, single-end bits and a parity pattern. A Gray-mapping error in the decoder or the write path would show up as swapped entries. Reprogramming from all ones to a sparse table catches a sequencer that skips the erase pass, because stale ones would survive. Busy length is measured against 16 plus the population count, which exposes an off-by-one erase count or writes issued for zero entries. During busy the bench toggles the inputs and pulses a second load. A design that leaks live data, lets the flip-flop capture, or accepts the second load would show a changed output or a wrong final table. Reset in registered mode must zero the output and then recover the old table without reloading.

// File: rtl/ble_pkg.sv
// Shared types and helpers for the lookup logic element.
// Assumes the table index width stays small (a few bits).
package ble_pkg;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_ERASE = 2'd1,
        MODE_WRITE = 2'd2
    } cell_mode_e;

    // Gray code of a physical position: the table entry that position stores.
    function automatic int unsigned gray_of(input int unsigned p);
        return p ^ (p >> 1);
    endfunction

endpackage

// File: rtl/ble_cfg_seq.sv
// Reprogramming sequencer. Erases every physical cell in order, then writes
// only the cells whose new entry is 1, lowest position first, then returns
// to read mode. Assumes cfg_table is valid in the cycle that cfg_load is high.
module ble_cfg_seq
    import ble_pkg::*;
#(
    parameter int unsigned K = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic [(1<<K)-1:0]   cfg_table,
    output logic                rd_en,
    output logic                wr_en,
    output logic                er_en,
    output logic [K-1:0]        pos,
    output logic                busy
);
    localparam int unsigned N = 1 << K;

    cell_mode_e      mode_q;
    logic [K-1:0]    pos_q;
    logic [N-1:0]    pend_q;
    logic [N-1:0]    phys_mask;
    logic [N-1:0]    pend_next;

    // Reorder the logical table into physical (Gray-placed) positions.
    for (genvar p = 0; p < N; p++) begin : g_phys
        localparam int unsigned ENT = gray_of(p);
        assign phys_mask[p] = cfg_table[ENT];
    end

    // Lowest set position of a pending mask.
    function automatic logic [K-1:0] lowest_set(input logic [N-1:0] m);
        logic [K-1:0] idx;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m[i]) idx = K'(i);
        end
        return idx;
    endfunction

    // Pending mask with the cell being written now removed.
    always_comb begin
        pend_next = pend_q;
        pend_next[pos_q] = 1'b0;
    end

    // Mode, position and pending-cell state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_READ;
            pos_q  <= '0;
            pend_q <= '0;
        end else begin
            case (mode_q)
                MODE_READ: begin
                    if (cfg_load) begin
                        mode_q <= MODE_ERASE;
                        pos_q  <= '0;
                        pend_q <= phys_mask;
                    end
                end
                MODE_ERASE: begin
                    if (pos_q == K'(N - 1)) begin
                        if (pend_q != '0) begin
                            mode_q <= MODE_WRITE;
                            pos_q  <= lowest_set(pend_q);
                        end else begin
                            mode_q <= MODE_READ;
                        end
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
                MODE_WRITE: begin
                    pend_q <= pend_next;
                    if (pend_next == '0) begin
                        mode_q <= MODE_READ;
                    end else begin
                        pos_q <= lowest_set(pend_next);
                    end
                end
                default: mode_q <= MODE_READ;
            endcase
        end
    end

    assign rd_en = (mode_q == MODE_READ);
    assign er_en = (mode_q == MODE_ERASE);
    assign wr_en = (mode_q == MODE_WRITE);
    assign busy  = (mode_q != MODE_READ);
    assign pos   = pos_q;

    // R2: one mode enable at a time.
    a_r2_onehot_modes: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_en, wr_en, er_en}) == 1);

    // R4: writing is only ever entered straight from the erase pass.
    a_r4_write_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> $past(er_en));

    // R3: erase only ends after the last physical cell.
    a_r3_full_erase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(er_en) |-> $past(pos) == K'(N - 1));

    // R3: a write cycle always targets a cell still pending.
    a_r3_write_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> pend_q[pos]);

endmodule

// File: rtl/ble_cell_array.sv
// Bit-cell store placed in Gray order, with a decoder driven by true and
// complemented address lines. Cells have no reset (nonvolatile behaviour).
// Assumes the sequencer supplies one-hot mode enables.
module ble_cell_array
    import ble_pkg::*;
#(
    parameter int unsigned K = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic            er_en,
    input  logic [K-1:0]    pos,
    input  logic [K-1:0]    addr,
    output logic            rd_data
);
    localparam int unsigned N = 1 << K;

    logic [N-1:0]   cells;
    logic [N-1:0]   sel;
    logic [K-1:0]   addr_t;
    logic [K-1:0]   addr_c;

    assign addr_t = addr;
    assign addr_c = ~addr;

    // Each physical cell matches the address equal to its Gray entry.
    for (genvar p = 0; p < N; p++) begin : g_dec
        localparam logic [K-1:0] ENT = K'(gray_of(p));
        assign sel[p] = &((addr_t & ENT) | (addr_c & ~ENT));
    end

    // Clear or set the cell named by pos in erase or write mode.
    always_ff @(posedge clk) begin
        for (int p = 0; p < N; p++) begin
            if (er_en && pos == K'(p)) begin
                cells[p] <= 1'b0;
            end else if (wr_en && pos == K'(p)) begin
                cells[p] <= 1'b1;
            end
        end
    end

    assign rd_data = rd_en & (|(sel & cells));

    // R9: the store is untouched while read mode persists.
    a_r9_read_keeps_cells: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && $past(rd_en) |-> $stable(cells));

    // R1: the decoder selects exactly one cell.
    a_r1_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(sel));

endmodule

// File: rtl/ble4_lut_element.sv
// Top of the logic element: sequencer, Gray-placed cell store, output flop,
// hold register and output select. The output mode is sampled with each
// accepted load and, like the table, survives reset.
module ble4_lut_element #(
    parameter int unsigned K = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [K-1:0]        lut_in,
    input  logic                cfg_load,
    input  logic [(1<<K)-1:0]   cfg_table,
    input  logic                cfg_registered,
    output logic                lut_out,
    output logic                busy
);
    logic            rd_en;
    logic            wr_en;
    logic            er_en;
    logic [K-1:0]    pos;
    logic            live;
    logic            ff_q;
    logic            hold_q;
    logic            reg_mode_q;

    ble_cfg_seq #(.K(K)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_table (cfg_table),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .er_en     (er_en),
        .pos       (pos),
        .busy      (busy)
    );

    ble_cell_array #(.K(K)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .er_en   (er_en),
        .pos     (pos),
        .addr    (lut_in),
        .rd_data (live)
    );

    // Output mode is configuration: taken with an accepted load, no reset.
    always_ff @(posedge clk) begin
        if (cfg_load && !busy) reg_mode_q <= cfg_registered;
    end

    // Output flop and hold register follow the live bit only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q   <= 1'b0;
            hold_q <= 1'b0;
        end else if (!busy) begin
            ff_q   <= live;
            hold_q <= live;
        end
    end

    assign lut_out = reg_mode_q ? ff_q : (busy ? hold_q : live);

    // R6: output frozen for the whole busy window.
    a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(lut_out));

endmodule

// File: tb/ble4_lut_element_tb.sv
// Sweeps every index over several tables in both output modes, measures busy
// length, and probes hold, ignored-load and reset behaviour.
module ble4_lut_element_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  lut_in = '0;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_table = '0;
    logic        cfg_registered = 1'b0;
    logic        lut_out;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ble4_lut_element u_dut (
        .clk(clk), .rst_n(rst_n), .lut_in(lut_in), .cfg_load(cfg_load),
        .cfg_table(cfg_table), .cfg_registered(cfg_registered),
        .lut_out(lut_out), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Load a table and count busy cycles; returns the count.
    task automatic load_table(input logic [15:0] tbl, input logic regd,
                              output int cnt);
        @(negedge clk);
        cfg_table = tbl; cfg_registered = regd; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    // Full sweep of all indices in the current mode.
    task automatic sweep(input logic [15:0] tbl, input logic regd, input string req);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            lut_in = 4'(a);
            if (regd) begin
                @(negedge clk);
                #1;
            end else begin
                #2;
            end
            chk(req, int'(lut_out), int'(tbl[a]));
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [15:0] tabs [5];
        tabs[0] = 16'hA5C3; tabs[1] = 16'h0000; tabs[2] = 16'hFFFF;
        tabs[3] = 16'h8001; tabs[4] = 16'h6996;

        repeat (3) @(negedge clk);
        chk("R2 reset idle", int'(busy), 0);
        rst_n = 1'b1;

        // R1, R3: each table in combinational mode, busy length measured.
        foreach (tabs[i]) begin
            load_table(tabs[i], 1'b0, cnt);
            chk("R3 busy length", cnt, 16 + $countones(tabs[i]));
            sweep(tabs[i], 1'b0, "R1 comb lookup");
        end

        // R4: all ones then a sparse table; stale ones must be gone.
        load_table(16'hFFFF, 1'b0, cnt);
        load_table(16'h0100, 1'b0, cnt);
        chk("R4 busy length", cnt, 17);
        sweep(16'h0100, 1'b0, "R4 erase before write");

        // R5: registered mode sweep over two tables.
        load_table(16'h3C5A, 1'b1, cnt);
        sweep(16'h3C5A, 1'b1, "R5 registered lookup");
        load_table(16'hF00F, 1'b1, cnt);
        sweep(16'hF00F, 1'b1, "R5 registered lookup");

        // R6 and R7: combinational, index 4 holds 1; reload with 0 there.
        load_table(16'h0010, 1'b0, cnt);
        @(negedge clk); lut_in = 4'd4; #2;
        chk("R6 pre-load value", int'(lut_out), 1);
        @(negedge clk);
        cfg_table = 16'h00E0; cfg_registered = 1'b0; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        cnt = 0;
        for (int c = 0; c < 40 && busy; c++) begin
            cnt++;
            lut_in = 4'(c);
            if (c == 3) begin
                cfg_table = 16'hFFFF; cfg_registered = 1'b1; cfg_load = 1'b1;
            end else begin
                cfg_load = 1'b0;
            end
            #2;
            chk("R6 output held", int'(lut_out), 1);
            @(negedge clk);
        end
        cfg_load = 1'b0;
        chk("R7 busy unchanged", cnt, 19);
        sweep(16'h00E0, 1'b0, "R7 second load ignored");

        // R6 registered: flop must not capture during busy.
        load_table(16'h0001, 1'b1, cnt);
        @(negedge clk); lut_in = 4'd0;
        @(negedge clk); #1;
        chk("R6 reg pre-load", int'(lut_out), 1);
        @(negedge clk);
        cfg_table = 16'h0000; cfg_registered = 1'b1; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        repeat (5) begin
            #1;
            chk("R6 reg held", int'(lut_out), 1);
            @(negedge clk);
        end
        while (busy) @(negedge clk);

        // R8: reset clears the flop, keeps table and mode.
        load_table(16'h0400, 1'b1, cnt);
        @(negedge clk); lut_in = 4'd10;
        @(negedge clk); #1;
        chk("R8 before reset", int'(lut_out), 1);
        rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R8 flop cleared", int'(lut_out), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R8 table retained", int'(lut_out), 1);
        chk("R8 idle after reset", int'(busy), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule